// File: doc/BRIEF.md
# General-Purpose Event Register Bank

This block keeps a small bank of byte-wide event status and event enable registers, reached through a byte-addressed window of `LEN` bytes that begins at a base address supplied at run time. The window is divided into two equal halves. The lower half holds the status bytes and the upper half holds the enable bytes, so status byte *k* and enable byte *k* sit exactly `LEN/2` apart. Software clears status bits by writing ones to them and programs enables with plain writes. Hardware sources set status bits directly.

One status bit has a fixed role: bit 1 of status byte 0 records a device insertion or removal. The block drives a level `evt_pending` whenever that hotplug bit is set and also enabled in enable byte 0. This level is meant to be ORed into the system control interrupt elsewhere. Each access is taken in one cycle. A registered response follows one cycle later and carries read data zero-extended to the bus width, together with an error flag for offsets that fall outside the window.

Top module: `gpe_bank`

## Requirements
- R1: Reset clears every status byte and every enable byte, so each of them reads back as 0x00 and `evt_pending` is low.
- R2: The window offset is `req_addr - base_addr`, taken modulo 2^ADDR_W. Changing `base_addr` moves the whole window. An address below the base wraps to a large offset and is illegal.
- R3: An offset below LEN/2 selects status byte [offset]. An offset from LEN/2 to LEN-1 selects enable byte [offset - LEN/2].
- R4: A write to a status byte clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: A write to an enable byte replaces it with the written value.
- R6: Every accepted request (`req_valid` high at a clock edge) produces `rsp_valid` high for exactly the following cycle. For a legal read, `rd_data` holds the selected byte in bits [7:0], and the upper bits are zero. For a write, `rd_data` is zero.
- R7: An offset of LEN or more sets `rsp_err` in the response and returns `rd_data` = 0. A write to such an offset changes no register.
- R8: A pulse on `hp_insert` or `hp_remove` sets bit 1 of status byte 0 at the next clock edge.
- R9: A high bit of `hw_set` (bit 8*k+b maps to status byte k, bit b) sets that status bit at the next clock edge.
- R10: `evt_pending` is high exactly when bit 1 is set in both status byte 0 and enable byte 0. It reflects each write from the cycle after that write, and no other status or enable bit affects it.
- R11: When a hardware set and a software clear reach the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_addr | input | ADDR_W | Base address of the window |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Absolute byte address |
| req_wdata | input | 8 | Write byte |
| hw_set | input | 4*LEN | Hardware set pulses, one per status bit |
| hp_insert | input | 1 | Device insertion event |
| hp_remove | input | 1 | Device removal event |
| rd_data | output | RD_W | Response data, zero-extended |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Response offset was out of range |
| evt_pending | output | 1 | Enabled hotplug event pending |

## Verification
Several properties are checked on every cycle by the assertions. These include the one-cycle response timing, the zero upper bits and the zero data on error responses. They also cover the clear-on-one and replace semantics of each byte, the priority of hardware sets over clears, the hotplug bit being set after an event, and enable bytes staying unchanged after an illegal write. Other behaviour can only be shown by the bench's scenarios. Those scenarios cover the address arithmetic against a moving base, the mapping of each offset onto the correct byte, the masking that lets only the hotplug bit drive `evt_pending`, and the full clearing effect of reset.

// File: rtl/gpe_pkg.sv
package gpe_pkg;

    // Which half of the window an offset falls in
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STS  = 2'd1,
        SEL_EN   = 2'd2
    } gpe_sel_e;

endpackage

// File: rtl/gpe_decode.sv
module gpe_decode
    import gpe_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN    = 4,
    parameter int IDX_W  = 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    output gpe_sel_e          sel,
    output logic [IDX_W-1:0]  idx
);
    localparam int HALF = LEN / 2;

    logic [ADDR_W-1:0] off;

    always_comb begin
        off = addr - base;
        sel = SEL_NONE;
        idx = '0;
        if (off < ADDR_W'(HALF)) begin
            sel = SEL_STS;
            idx = IDX_W'(off);
        end else if (off < ADDR_W'(LEN)) begin
            sel = SEL_EN;
            idx = IDX_W'(off - ADDR_W'(HALF));
        end
    end
endmodule

// File: rtl/gpe_status_byte.sv
module gpe_status_byte (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wd,
    input  logic [7:0] set,
    output logic [7:0] q
);
    logic [7:0] clr;

    assign clr = wr_en ? wd : 8'h00;

    // set is applied after the clear, so it wins on a shared bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 8'h00;
        else        q <= (q & ~clr) | set;
    end

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((q & $past(wd) & ~$past(set)) == 8'h00)); // R4
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> ((q & $past(set)) == $past(set))); // R11
endmodule

// File: rtl/gpe_enable_byte.sv
module gpe_enable_byte (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wd,
    output logic [7:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= 8'h00;
        else if (wr_en) q <= wd;
    end

    AST_EN_REPLACE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (q == $past(wd))); // R5
endmodule

// File: rtl/gpe_bank.sv
module gpe_bank
    import gpe_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN    = 4,
    parameter int RD_W   = 32,
    parameter int HP_BIT = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     base_addr,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [7:0]            req_wdata,
    input  logic [(LEN/2)*8-1:0]  hw_set,
    input  logic                  hp_insert,
    input  logic                  hp_remove,
    output logic [RD_W-1:0]       rd_data,
    output logic                  rsp_valid,
    output logic                  rsp_err,
    output logic                  evt_pending
);
    localparam int         HALF    = LEN / 2;
    localparam int         IDX_W   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [7:0] HP_MASK = 8'(1 << HP_BIT);

    gpe_sel_e         sel;
    logic [IDX_W-1:0] idx;
    logic [7:0]       sts_q [HALF];
    logic [7:0]       en_q  [HALF];
    logic [HALF*8-1:0] en_flat;
    logic [7:0]       rd_byte;
    logic             acc_wr;
    logic             hp_evt;

    gpe_decode #(.ADDR_W(ADDR_W), .LEN(LEN), .IDX_W(IDX_W)) u_decode (
        .addr (req_addr),
        .base (base_addr),
        .sel  (sel),
        .idx  (idx)
    );

    assign acc_wr = req_valid && req_write;
    assign hp_evt = hp_insert || hp_remove;

    for (genvar i = 0; i < HALF; i++) begin : g_byte
        logic [7:0] set_i;
        assign set_i = hw_set[i*8 +: 8] | ((i == 0 && hp_evt) ? HP_MASK : 8'h00);

        gpe_status_byte u_sts (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (acc_wr && sel == SEL_STS && idx == IDX_W'(i)),
            .wd    (req_wdata),
            .set   (set_i),
            .q     (sts_q[i])
        );

        gpe_enable_byte u_en (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (acc_wr && sel == SEL_EN && idx == IDX_W'(i)),
            .wd    (req_wdata),
            .q     (en_q[i])
        );

        assign en_flat[i*8 +: 8] = en_q[i];
    end

    always_comb begin
        unique case (sel)
            SEL_STS: rd_byte = sts_q[idx];
            SEL_EN:  rd_byte = en_q[idx];
            default: rd_byte = 8'h00;
        endcase
    end

    // Registered response, one cycle after the request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rd_data   <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && (sel == SEL_NONE);
            rd_data   <= (req_valid && !req_write) ? RD_W'(rd_byte) : '0;
        end
    end

    assign evt_pending = |(sts_q[0] & en_q[0] & HP_MASK);

    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R6
    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R6
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[RD_W-1:8] == '0); // R6
    AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rd_data == '0)); // R7
    AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && sel == SEL_NONE) |=> $stable(en_flat)); // R7
    AST_HP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        hp_evt |=> sts_q[0][HP_BIT]); // R8
endmodule

// File: tb/gpe_bank_tb.sv
`timescale 1ns/1ps
module gpe_bank_tb;
    localparam int ADDR_W = 16;
    localparam int LEN    = 4;
    localparam int RD_W   = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] base_addr = 16'h0AF0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [7:0]        req_wdata = '0;
    logic [15:0]       hw_set = '0;
    logic              hp_insert = 1'b0;
    logic              hp_remove = 1'b0;
    logic [RD_W-1:0]   rd_data;
    logic              rsp_valid;
    logic              rsp_err;
    logic              evt_pending;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [RD_W-1:0] q_data [$];
    bit              q_err  [$];
    int              q_req  [$];

    always #10 clk = ~clk;

    gpe_bank #(.ADDR_W(ADDR_W), .LEN(LEN), .RD_W(RD_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .base_addr(base_addr),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .hw_set(hw_set), .hp_insert(hp_insert),
        .hp_remove(hp_remove), .rd_data(rd_data), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .evt_pending(evt_pending)
    );

    // Monitor: pops expected responses in order
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            n_vec++;
            if (q_data.size() == 0) begin
                n_bad++;
                $display("FAIL R6 unexpected response: actual data=%h err=%b expected none",
                         rd_data, rsp_err);
            end else begin
                automatic logic [RD_W-1:0] ed = q_data.pop_front();
                automatic bit ee = q_err.pop_front();
                automatic int er = q_req.pop_front();
                if (rd_data !== ed || rsp_err !== ee) begin
                    n_bad++;
                    $display("FAIL R%0d response: actual data=%h err=%b expected data=%h err=%b",
                             er, rd_data, rsp_err, ed, ee);
                end
            end
        end
    end

    task automatic drive(input bit wr, input logic [ADDR_W-1:0] a, input logic [7:0] d,
                         input logic [RD_W-1:0] exp_d, input bit exp_e, input int req);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        q_data.push_back(exp_d); q_err.push_back(exp_e); q_req.push_back(req);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic chk_pend(input logic exp, input int req);
        n_vec++;
        if (evt_pending !== exp) begin
            n_bad++;
            $display("FAIL R%0d evt_pending: actual %b expected %b", req, evt_pending, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 5000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: all bytes read zero after reset
        chk_pend(1'b0, 1);
        for (int i = 0; i < LEN; i++) drive(0, 16'h0AF0 + 16'(i), 8'h00, 32'h0, 0, 1);
        // R5, R3: enable bytes at offsets 2 and 3
        drive(1, 16'h0AF2, 8'hFF, 32'h0, 0, 5);
        drive(0, 16'h0AF2, 8'h00, 32'hFF, 0, 5);
        drive(1, 16'h0AF3, 8'h5A, 32'h0, 0, 3);
        drive(0, 16'h0AF3, 8'h00, 32'h5A, 0, 3);
        // R9: hardware set of status byte 1
        @(negedge clk); hw_set = 16'h0F00;
        @(negedge clk); hw_set = '0;
        drive(0, 16'h0AF1, 8'h00, 32'h0F, 0, 9);
        // R4: clear on one
        drive(1, 16'h0AF1, 8'h05, 32'h0, 0, 4);
        drive(0, 16'h0AF1, 8'h00, 32'h0A, 0, 4);
        // R8, R10: insertion event raises pending
        @(negedge clk); hp_insert = 1'b1;
        @(negedge clk); hp_insert = 1'b0;
        chk_pend(1'b1, 10);
        drive(0, 16'h0AF0, 8'h00, 32'h02, 0, 8);
        // R4, R10: clearing hotplug bit drops pending
        drive(1, 16'h0AF0, 8'h02, 32'h0, 0, 4);
        chk_pend(1'b0, 10);
        // R10: another enabled bit of byte 0 does not raise pending
        @(negedge clk); hw_set = 16'h0001;
        @(negedge clk); hw_set = '0;
        chk_pend(1'b0, 10);
        drive(0, 16'h0AF0, 8'h00, 32'h01, 0, 9);
        // R7: out-of-range write and read
        drive(1, 16'h0AF4, 8'hFF, 32'h0, 1, 7);
        drive(0, 16'h0AF3, 8'h00, 32'h5A, 0, 7);
        drive(0, 16'h0AF2, 8'h00, 32'hFF, 0, 7);
        drive(0, 16'h0AF4, 8'h00, 32'h0, 1, 7);
        // R2: below the base wraps to illegal
        drive(0, 16'h0AEF, 8'h00, 32'h0, 1, 2);
        // R11: removal event and clear of the same bit in one cycle
        @(negedge clk);
        hp_remove = 1'b1;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0AF0; req_wdata = 8'h02;
        q_data.push_back(32'h0); q_err.push_back(1'b0); q_req.push_back(11);
        @(negedge clk);
        hp_remove = 1'b0; req_valid = 1'b0;
        chk_pend(1'b1, 11);
        drive(0, 16'h0AF0, 8'h00, 32'h03, 0, 11);
        // R10: disabling enable byte 0 drops pending
        drive(1, 16'h0AF2, 8'h00, 32'h0, 0, 10);
        chk_pend(1'b0, 10);
        // R2: moving the base moves the window
        base_addr = 16'h0B00;
        drive(0, 16'h0B03, 8'h00, 32'h5A, 0, 2);
        drive(0, 16'h0AF3, 8'h00, 32'h0, 1, 2);
        // R1: reset again clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < LEN; i++) drive(0, 16'h0B00 + 16'(i), 8'h00, 32'h0, 0, 1);
        chk_pend(1'b0, 1);
        repeat (2) @(negedge clk);
        if (q_data.size() != 0) begin
            n_bad++;
            $display("FAIL R6 missing responses: actual %0d outstanding expected 0", q_data.size());
        end
        finish_run();
    end
endmodule